// File: doc/BRIEF.md
# Interrupting 64-bit Message Mailbox

This block is a message mailbox that holds 64-bit messages delivered by incoming link transactions. Each message arrives on a single-cycle push port and is kept in a first-in first-out store whose depth is a parameter. Software drains the store through a small register port. Two 32-bit data registers expose the two halves of the oldest message. A third register reports the occupancy, the flags and a sticky overflow indication.

The pop is a side effect of a read. Software reads the lower half of the head message first and the upper half second. The read of the upper half retires the message. A not-empty output can drive an interrupt line directly. A full output is also provided. A maskable interrupt output follows the not-empty state whenever the enable input is high.

Register read data is combinational on the register address. A read strobe is needed only for the pop side effect. A push that meets a full store is discarded and recorded in the sticky overflow flag.

Top module: `msg_mailbox`

## Requirements
- R1: Register address 0 returns bits [31:0] and address 1 returns bits [63:32] of the oldest stored message. Both return zero while the mailbox is empty. Address 3 always returns zero.
- R2: A read strobe on address 0 has no side effect. A read strobe on address 1 while the mailbox is not empty removes the oldest message at the next clock edge, so the count drops by one.
- R3: A read strobe on address 1 while the mailbox is empty returns zero and removes nothing. A push in the same cycle is still accepted.
- R4: The status register at address 2 has bit 0 set when not empty, bit 1 set when full (count equal to DEPTH), and bit 2 set when the count is at least DEPTH/2. It carries the overflow flag in bit 3 and the message count in bits [31:16]. All other bits read as zero.
- R5: A push while the mailbox is full is discarded and sets the overflow flag (status bit 3). The flag stays set until any write strobe to address 2. If a discarded push arrives in the same cycle as that write, the flag stays set.
- R6: A push and a pop in the same cycle on a mailbox that is neither empty nor full leave the count unchanged. The pushed message is added behind the remaining ones.
- R7: not_empty_o is high exactly when at least one message is stored. full_o is high exactly when DEPTH messages are stored.
- R8: irq_o is high exactly when irq_en_i is high and the mailbox is not empty.
- R9: After reset the mailbox is empty, the overflow flag is clear and the status register reads zero.
- R10: Messages leave in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Message push strobe |
| push_data_i | input | 64 | Message to store |
| reg_addr_i | input | 2 | Register select: 0 low word, 1 high word, 2 status |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data (value ignored) |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_en_i | input | 1 | Interrupt enable |
| not_empty_o | output | 1 | At least one message stored |
| full_o | output | 1 | Mailbox full |
| irq_o | output | 1 | Masked mailbox interrupt |

## Verification
The bench builds the mailbox with DEPTH set to 4. With that depth, the full boundary, the half-full threshold of two and the overflow drop are reached after only a few pushes. The pointers also wrap many times during the mixed random phase. A behavioural queue model is compared with the read data and the three flag outputs on every clock. Directed phases cover an empty high read that coincides with a push, and simultaneous push and pop at partial occupancy.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned MSG_W = 2 * WORD_W;
  localparam int unsigned STAT_CNT_LSB = 16;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned MSG_W = 64,
  localparam int unsigned PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [MSG_W-1:0] push_data_i,
  input  logic             pop_i,
  output logic [MSG_W-1:0] head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [MSG_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CAP);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic              push_i,
  input  logic [MSG_W-1:0]  head_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              empty_i,
  input  logic              full_i,
  output logic              pop_o,
  output logic              ovf_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  reg_sel_e sel;
  logic ovf_q, ovf_set, ovf_clr;
  logic [WORD_W-1:0] status;

  assign sel     = reg_sel_e'(reg_addr_i);
  assign pop_o   = reg_rd_i && (sel == REG_HI);
  assign ovf_set = push_i && full_i;
  assign ovf_clr = reg_wr_i && (sel == REG_STAT);
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= (ovf_q && !ovf_clr) || ovf_set;
  end

  always_comb begin
    status = '0;
    status[0] = !empty_i;
    status[1] = full_i;
    status[2] = (count_i >= HALF);
    status[3] = ovf_q;
    status[STAT_CNT_LSB +: CNT_W] = count_i;
  end

  always_comb begin
    unique case (sel)
      REG_LO:   rdata_o = empty_i ? '0 : head_i[WORD_W-1:0];
      REG_HI:   rdata_o = empty_i ? '0 : head_i[MSG_W-1:WORD_W];
      REG_STAT: rdata_o = status;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  input  logic [MSG_W-1:0]  push_data_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic              irq_en_i,
  output logic              not_empty_o,
  output logic              full_o,
  output logic              irq_o
);
  logic [MSG_W-1:0] head;
  logic [CNT_W-1:0] cnt;
  logic empty, full, pop, ovf;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  mbox_store #(.DEPTH(DEPTH), .MSG_W(MSG_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_valid_i),
    .push_data_i (push_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .count_o     (cnt),
    .empty_o     (empty),
    .full_o      (full)
  );

  mbox_regs #(.DEPTH(DEPTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_addr_i (reg_addr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_wr_i   (reg_wr_i),
    .push_i     (push_valid_i),
    .head_i     (head),
    .count_i    (cnt),
    .empty_i    (empty),
    .full_i     (full),
    .pop_o      (pop),
    .ovf_o      (ovf),
    .rdata_o    (reg_rdata_o)
  );

  assign not_empty_o = !empty;
  assign full_o      = full;
  assign irq_o       = irq_en_i && !empty;
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_valid_i,
  input logic [1:0]       reg_addr_i,
  input logic             reg_rd_i,
  input logic             reg_wr_i,
  input logic             irq_en_i,
  input logic             not_empty_o,
  input logic             full_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] count,
  input logic             ovf
);
  logic hi_rd;
  assign hi_rd = reg_rd_i && (reg_addr_i == 2'd1);

  p_pop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_rd && not_empty_o && !push_valid_i) |=> (count == $past(count) - 1'b1));

  p_empty_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_rd && !not_empty_o && !push_valid_i) |=> (count == '0));

  p_overflow_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && full_o) |=> ovf);

  p_overflow_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd2 && !(push_valid_i && full_o)) |=> !ovf);

  p_simul_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && hi_rd && not_empty_o && !full_o) |=> (count == $past(count)));

  p_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (not_empty_o && count == CNT_W'(DEPTH)));

  p_irq_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && count != '0));

  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && count != '0) |-> irq_o);
endmodule

bind msg_mailbox mbox_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_valid_i (push_valid_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_wr_i     (reg_wr_i),
  .irq_en_i     (irq_en_i),
  .not_empty_o  (not_empty_o),
  .full_o       (full_o),
  .irq_o        (irq_o),
  .count        (cnt),
  .ovf          (ovf)
);

// File: tb/test_msg_mailbox.sv
`timescale 1ns/1ps
module test_msg_mailbox;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0;
  logic [63:0] pdata = '0;
  logic [1:0]  addr = 2'd2;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_en = 1'b0;
  logic        nempty, full, irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [63:0] q[$];
  bit ovf_m = 0;

  always #2 clk = ~clk;

  msg_mailbox #(.DEPTH(DEPTH)) i_msg_mailbox (
    .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push), .push_data_i(pdata),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_en_i(irq_en), .not_empty_o(nempty),
    .full_o(full), .irq_o(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(logic [1:0] a);
    int n = q.size();
    case (a)
      2'd0: return (n > 0) ? q[0][31:0] : 32'h0;
      2'd1: return (n > 0) ? q[0][63:32] : 32'h0;
      2'd2: return {16'(n), 12'h0, ovf_m, (n >= DEPTH/2), (n == DEPTH), (n > 0)};
      default: return 32'h0;
    endcase
  endfunction

  // one clock: drive at negedge, compare before the edge, update model after it
  task automatic cyc(string req, bit p, logic [63:0] d, logic [1:0] a, bit r, bit w);
    int n;
    bit pop_ok, push_ok;
    @(negedge clk);
    push = p; pdata = d; addr = a; rd = r; wr = w; wdata = $urandom;
    #1;
    chk(req, "rdata", rdata, exp_rdata(a));
    chk(req, "not_empty (R7)", {31'b0, nempty}, {31'b0, q.size() > 0});
    chk(req, "full (R7)", {31'b0, full}, {31'b0, q.size() == DEPTH});
    chk(req, "irq (R8)", {31'b0, irq}, {31'b0, irq_en && q.size() > 0});
    @(posedge clk);
    n = q.size();
    pop_ok  = r && a == 2'd1 && n > 0;
    push_ok = p && n < DEPTH;
    ovf_m = (ovf_m && !(w && a == 2'd2)) || (p && n == DEPTH);
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(d);
  endtask

  function automatic logic [63:0] msg(int k);
    return {32'hA500_0000 + 32'(k), 32'h0000_5A00 + 32'(k * 3)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    cyc("R9", 0, '0, 2'd2, 0, 0);
    cyc("R9", 0, '0, 2'd0, 0, 0);
    cyc("R9", 0, '0, 2'd3, 0, 0);
    // R10: fill in order, irq masked (R8)
    for (int k = 0; k < 3; k++) cyc("R10", 1, msg(k), 2'd2, 0, 0);
    cyc("R8", 0, '0, 2'd2, 0, 0);
    irq_en = 1'b1;
    cyc("R8", 0, '0, 2'd0, 0, 0);
    // R2: low read has no side effect
    cyc("R2", 0, '0, 2'd0, 1, 0);
    cyc("R2", 0, '0, 2'd0, 1, 0);
    cyc("R2", 0, '0, 2'd2, 0, 0);
    cyc("R2", 0, '0, 2'd1, 1, 0);
    cyc("R2", 0, '0, 2'd2, 0, 0);
    cyc("R1", 0, '0, 2'd0, 0, 0);
    // R4/R5: reach full, push beyond it
    cyc("R4", 1, msg(10), 2'd2, 0, 0);
    cyc("R4", 1, msg(11), 2'd2, 0, 0);
    cyc("R5", 1, msg(12), 2'd2, 0, 0);
    cyc("R5", 0, '0, 2'd2, 0, 0);
    cyc("R5", 0, '0, 2'd3, 0, 1);   // write elsewhere keeps flag
    cyc("R5", 0, '0, 2'd2, 0, 1);   // clear
    cyc("R5", 1, msg(13), 2'd2, 0, 1); // set wins over clear
    cyc("R5", 0, '0, 2'd2, 0, 1);
    cyc("R5", 0, '0, 2'd2, 0, 0);
    // R6: simultaneous push and pop at partial occupancy
    cyc("R6", 0, '0, 2'd1, 1, 0);
    cyc("R6", 1, msg(20), 2'd1, 1, 0);
    cyc("R6", 1, msg(21), 2'd1, 1, 0);
    cyc("R6", 0, '0, 2'd2, 0, 0);
    // R1/R10: drain
    for (int k = 0; k < 4; k++) begin
      cyc("R1", 0, '0, 2'd0, 1, 0);
      cyc("R1", 0, '0, 2'd1, 1, 0);
    end
    // R3: high read on empty, alone and with a push
    cyc("R3", 0, '0, 2'd1, 1, 0);
    cyc("R3", 0, '0, 2'd2, 0, 0);
    cyc("R3", 1, msg(30), 2'd1, 1, 0);
    cyc("R3", 0, '0, 2'd2, 0, 0);
    cyc("R3", 0, '0, 2'd1, 1, 0);
    // R10: mixed traffic with pointer wrap
    for (int k = 0; k < 400; k++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      irq_en = 1'($urandom);
      cyc("R10", 1'($urandom), {$urandom, $urandom}, a, 1'($urandom), ($urandom_range(0, 7) == 0));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule